// File: doc/BRIEF.md
# GPIO Port Register File with Atomic Set/Reset

This block holds the software-visible state of one 16-pin general-purpose I/O port and turns it into per-pin pad controls. A simple 32-bit register bus writes and reads it. Each access gives a word index, four byte strobes and write data, and reads return data in the same cycle. The block holds these configuration fields for each pin:

- a 2-bit mode
- a push-pull/open-drain select
- a 2-bit drive speed
- a 2-bit pull select
- a 4-bit alternate-function select

It also holds the output data word and a registered sample of the pin inputs.

Software changes any subset of output bits in one write through two write-only registers. One is a combined set/clear register, where set wins over clear. The other is a clear-only register. A separate lock block supplies a 16-bit mask. Any pin whose mask bit is high keeps its configuration fields unchanged under writes, while the other pins still accept them.

The pin multiplexer chooses each pin's driven value and output enable. The choice depends on the pin's mode, on its alternate-function select and on a bank of 16 alternate-function output/enable pairs per pin. In open-drain style the pin is only driven when the value is low.

Top module: `gpio_port_regs`

## Requirements
- R1: After reset, every pin's mode field reads 11 (analog), so the mode register reads 0xFFFFFFFF. The output type, speed, pull, both alternate-function registers and the output data register read 0. No pin has its output enable high.
- R2: Writes to the mode (word 0), output type (word 1), speed (word 2), pull (word 3), output data (word 5), alternate-function low (word 8) and alternate-function high (word 9) registers update only the byte lanes whose strobe is high. A read in the following cycle returns the merged value.
- R3: A write to the set/clear register (word 6) sets output data bit p when write bit p is 1 and clears it when write bit 16+p is 1. If both bits are 1, the output bit becomes 1. A 0 bit, or a bit in a disabled byte lane, leaves the output bit unchanged.
- R4: A write to the clear-only register (word 10) clears output data bit p wherever write bit p is 1. Its bits 31:16 have no effect.
- R5: Reads of words 6 and 10 return 0. Bits 31:16 of the output type, input data and output data registers read as 0.
- R6: The input data register (word 4) captures the pin inputs at every clock edge, so a change on a pin is visible one edge later. A pin in analog mode reads 0.
- R7: While lock mask bit p is 1, writes leave pin p's mode, output type, speed, pull and alternate-function fields unchanged. Fields of unlocked pins in the same write still update.
- R8: The output enable is high only for a pin in output mode (01), or in alternate-function mode (10) when the selected function's enable input is high. The driven value is the selected alternate-function output in mode 10 and the output data bit in every other mode.
- R9: With output type 1 (open-drain), the output enable is additionally forced low whenever the driven value is 1. Output type 0 (push-pull) drives both levels. The open-drain output reflects the type bit.
- R10: The pull-up output is high for pull field 01, the pull-down output is high for 10, and neither is high for 00 or 11.
- R11: Pin p (0..7) takes its 4-bit alternate-function select from bits 4p+3:4p of word 8, and pin p (8..15) from bits 4(p-8)+3:4(p-8) of word 9. Select value f picks alternate-function input index 16p+f.
- R12: The mode output presents each pin's 2-bit mode field at bits 2p+1:2p (00 input, 01 output, 10 alternate function, 11 analog).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_word | input | 6 | Word index (byte offset divided by 4) |
| bus_be | input | 4 | Byte lane write strobes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as a read |
| lock_mask | input | 16 | Per-pin configuration freeze from the lock block |
| pin_in | input | 16 | Pin input levels |
| af_out | input | 256 | Alternate-function output values, index 16p+f |
| af_oe | input | 256 | Alternate-function output requests, index 16p+f |
| pin_out | output | 16 | Value presented to each pin driver |
| pin_oe | output | 16 | Per-pin driver enable |
| pin_od | output | 16 | Per-pin open-drain style |
| pin_pu | output | 16 | Per-pin pull-up enable |
| pin_pd | output | 16 | Per-pin pull-down enable |
| pin_mode | output | 32 | Per-pin mode field |
| pin_speed | output | 32 | Per-pin speed field |

## Verification
The set/clear register is swept exhaustively for every pin. Every combination of set bit, clear bit and prior output level is tried against a background pattern, which separates set priority, plain clear, no-op writes and disturbance of neighbouring bits. The byte-lane merge is tried with every non-zero strobe combination on each writable register. The same is done with lane-restricted set/clear writes, so that a lane decoded as the wrong half shows up.

The pin multiplexer is swept across all four modes, four rotating alternate-function selects, both output types and two complementary output data patterns. A wrong select index, a wrong low/high register split or a missing open-drain gate each shows up on some pin. Lock tests use a mask that covers pins in both alternate-function registers, and the input sampler is checked for its one-edge latency and for analog masking.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned NPIN = 16;
  localparam int unsigned AFW  = 4;
  localparam int unsigned NAF  = 1 << AFW;

  typedef enum logic [1:0] {
    PM_IN  = 2'b00,
    PM_OUT = 2'b01,
    PM_ALT = 2'b10,
    PM_ANA = 2'b11
  } pin_mode_e;

  localparam logic [5:0] W_MODE  = 6'h00;
  localparam logic [5:0] W_OTYPE = 6'h01;
  localparam logic [5:0] W_SPEED = 6'h02;
  localparam logic [5:0] W_PULL  = 6'h03;
  localparam logic [5:0] W_IDR   = 6'h04;
  localparam logic [5:0] W_ODR   = 6'h05;
  localparam logic [5:0] W_BSR   = 6'h06;
  localparam logic [5:0] W_LOCK  = 6'h07;
  localparam logic [5:0] W_AFLO  = 6'h08;
  localparam logic [5:0] W_AFHI  = 6'h09;
  localparam logic [5:0] W_CLR   = 6'h0A;

  // byte strobes expanded to a bit mask
  function automatic logic [31:0] lane_bits(input logic [3:0] be);
    logic [31:0] m;
    for (int b = 0; b < 4; b++) m[8*b +: 8] = {8{be[b]}};
    return m;
  endfunction

  // per-bit freeze mask for a register holding fields of width fw, first pin "first"
  function automatic logic [31:0] spread_lock(input logic [15:0] lk, input int fw, input int first);
    logic [31:0] m;
    for (int k = 0; k < 32; k++) begin
      int idx;
      idx = first + k / fw;
      m[k] = (idx < 16) ? lk[idx[3:0]] : 1'b1;
    end
    return m;
  endfunction

  function automatic logic [31:0] merge_write(input logic [31:0] old, input logic [31:0] wd,
                                             input logic [3:0] be, input logic [31:0] frozen);
    logic [31:0] en;
    en = lane_bits(be) & ~frozen;
    return (old & ~en) | (wd & en);
  endfunction
endpackage

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [5:0]  wr_word,
  input  logic [31:0] wdata,
  input  logic [3:0]  be,
  input  logic [15:0] lock_mask,
  output logic [31:0] mode_q,
  output logic [15:0] otype_q,
  output logic [31:0] speed_q,
  output logic [31:0] pull_q,
  output logic [31:0] af_lo_q,
  output logic [31:0] af_hi_q
);
  logic [31:0] frz2, frz_lo, frz_hi, lanes;
  logic [15:0] otype_en;

  assign frz2     = spread_lock(lock_mask, 2, 0);
  assign frz_lo   = spread_lock(lock_mask, AFW, 0);
  assign frz_hi   = spread_lock(lock_mask, AFW, NPIN / 2);
  assign lanes    = lane_bits(be);
  assign otype_en = lanes[15:0] & ~lock_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '1;
      otype_q <= '0;
      speed_q <= '0;
      pull_q  <= '0;
      af_lo_q <= '0;
      af_hi_q <= '0;
    end else if (wr_en) begin
      case (wr_word)
        W_MODE:  mode_q  <= merge_write(mode_q, wdata, be, frz2);
        W_OTYPE: otype_q <= (otype_q & ~otype_en) | (wdata[15:0] & otype_en);
        W_SPEED: speed_q <= merge_write(speed_q, wdata, be, frz2);
        W_PULL:  pull_q  <= merge_write(pull_q, wdata, be, frz2);
        W_AFLO:  af_lo_q <= merge_write(af_lo_q, wdata, be, frz_lo);
        W_AFHI:  af_hi_q <= merge_write(af_hi_q, wdata, be, frz_hi);
        default: ;
      endcase
    end
  end

  for (genvar p = 0; p < NPIN; p++) begin : g_lock_chk
    logic [AFW-1:0] af_field;
    if (p < NPIN / 2) begin : g_lo
      assign af_field = af_lo_q[AFW*p +: AFW];
    end else begin : g_hi
      assign af_field = af_hi_q[AFW*(p - NPIN/2) +: AFW];
    end
    assert_lock_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      lock_mask[p] |=> ($stable(mode_q[2*p +: 2]) && $stable(otype_q[p]) &&
                        $stable(speed_q[2*p +: 2]) && $stable(pull_q[2*p +: 2]) &&
                        $stable(af_field)));
  end
endmodule

// File: rtl/gpio_data_regs.sv
module gpio_data_regs
  import gpio_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [5:0]  wr_word,
  input  logic [31:0] wdata,
  input  logic [3:0]  be,
  input  logic [15:0] pin_in,
  input  logic [15:0] analog_mask,
  output logic [15:0] odr_q,
  output logic [15:0] idr_q
);
  logic [31:0] lanes, strobed;
  logic        bsr_fire, clr_fire, odr_fire;
  logic [15:0] set_vec, clr_vec;

  assign lanes    = lane_bits(be);
  assign strobed  = wdata & lanes;
  assign bsr_fire = wr_en && (wr_word == W_BSR);
  assign clr_fire = wr_en && (wr_word == W_CLR);
  assign odr_fire = wr_en && (wr_word == W_ODR);
  assign set_vec  = bsr_fire ? strobed[15:0] : '0;
  assign clr_vec  = bsr_fire ? strobed[31:16] : (clr_fire ? strobed[15:0] : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      odr_q <= '0;
      idr_q <= '0;
    end else begin
      if (odr_fire) odr_q <= (odr_q & ~lanes[15:0]) | (wdata[15:0] & lanes[15:0]);
      else          odr_q <= (odr_q & ~clr_vec) | set_vec;
      idr_q <= pin_in & ~analog_mask;
    end
  end

  assert_set_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bsr_fire |=> ((odr_q & $past(set_vec)) == $past(set_vec)));
  assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bsr_fire || clr_fire) |=> ((odr_q & $past(clr_vec & ~set_vec)) == 16'h0));
  assert_sample_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (idr_q == $past(pin_in & ~analog_mask)));
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
  import gpio_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [31:0]         mode_q,
  input  logic [15:0]         otype_q,
  input  logic [31:0]         pull_q,
  input  logic [31:0]         af_lo_q,
  input  logic [31:0]         af_hi_q,
  input  logic [15:0]         odr_q,
  input  logic [NPIN*NAF-1:0] af_out,
  input  logic [NPIN*NAF-1:0] af_oe,
  output logic [15:0]         pin_out,
  output logic [15:0]         pin_oe,
  output logic [15:0]         pin_od,
  output logic [15:0]         pin_pu,
  output logic [15:0]         pin_pd,
  output logic [15:0]         analog_mask
);
  logic [15:0] out_mode_vec, alt_mode_vec;

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    pin_mode_e      md;
    logic [AFW-1:0] sel;
    logic [NAF-1:0] fo, fe;
    logic           alt_o, alt_e, val, req;

    assign md = pin_mode_e'(mode_q[2*p +: 2]);
    if (p < NPIN / 2) begin : g_lo
      assign sel = af_lo_q[AFW*p +: AFW];
    end else begin : g_hi
      assign sel = af_hi_q[AFW*(p - NPIN/2) +: AFW];
    end
    assign fo    = af_out[NAF*p +: NAF];
    assign fe    = af_oe[NAF*p +: NAF];
    assign alt_o = fo[sel];
    assign alt_e = fe[sel];
    assign val   = (md == PM_ALT) ? alt_o : odr_q[p];
    assign req   = (md == PM_OUT) || ((md == PM_ALT) && alt_e);

    assign pin_out[p]      = val;
    assign pin_od[p]       = otype_q[p];
    assign pin_oe[p]       = req && !(otype_q[p] && val);
    assign pin_pu[p]       = (pull_q[2*p +: 2] == 2'b01);
    assign pin_pd[p]       = (pull_q[2*p +: 2] == 2'b10);
    assign analog_mask[p]  = (md == PM_ANA);
    assign out_mode_vec[p] = (mode_q[2*p +: 2] == 2'b01);
    assign alt_mode_vec[p] = (mode_q[2*p +: 2] == 2'b10);
  end

  assert_oe_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe & ~(out_mode_vec | alt_mode_vec)) == 16'h0);
  assert_od_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe & pin_od & pin_out) == 16'h0);
  assert_pull_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_pu & pin_pd) == 16'h0);
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_we,
  input  logic [5:0]          bus_word,
  input  logic [3:0]          bus_be,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [15:0]         lock_mask,
  input  logic [15:0]         pin_in,
  input  logic [NPIN*NAF-1:0] af_out,
  input  logic [NPIN*NAF-1:0] af_oe,
  output logic [15:0]         pin_out,
  output logic [15:0]         pin_oe,
  output logic [15:0]         pin_od,
  output logic [15:0]         pin_pu,
  output logic [15:0]         pin_pd,
  output logic [31:0]         pin_mode,
  output logic [31:0]         pin_speed
);
  logic        wr_en;
  logic [31:0] mode_q, speed_q, pull_q, af_lo_q, af_hi_q;
  logic [15:0] otype_q, odr_q, idr_q, analog_mask;

  assign wr_en = bus_sel && bus_we;

  gpio_cfg_regs u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_word(bus_word), .wdata(bus_wdata),
    .be(bus_be), .lock_mask(lock_mask), .mode_q(mode_q), .otype_q(otype_q),
    .speed_q(speed_q), .pull_q(pull_q), .af_lo_q(af_lo_q), .af_hi_q(af_hi_q)
  );

  gpio_data_regs u_data (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_word(bus_word), .wdata(bus_wdata),
    .be(bus_be), .pin_in(pin_in), .analog_mask(analog_mask), .odr_q(odr_q), .idr_q(idr_q)
  );

  gpio_pin_mux u_mux (
    .clk(clk), .rst_n(rst_n), .mode_q(mode_q), .otype_q(otype_q), .pull_q(pull_q),
    .af_lo_q(af_lo_q), .af_hi_q(af_hi_q), .odr_q(odr_q), .af_out(af_out), .af_oe(af_oe),
    .pin_out(pin_out), .pin_oe(pin_oe), .pin_od(pin_od), .pin_pu(pin_pu), .pin_pd(pin_pd),
    .analog_mask(analog_mask)
  );

  assign pin_mode  = mode_q;
  assign pin_speed = speed_q;

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_we) begin
      case (bus_word)
        W_MODE:  bus_rdata = mode_q;
        W_OTYPE: bus_rdata = {16'h0, otype_q};
        W_SPEED: bus_rdata = speed_q;
        W_PULL:  bus_rdata = pull_q;
        W_IDR:   bus_rdata = {16'h0, idr_q};
        W_ODR:   bus_rdata = {16'h0, odr_q};
        W_LOCK:  bus_rdata = {16'h0, lock_mask};
        W_AFLO:  bus_rdata = af_lo_q;
        W_AFHI:  bus_rdata = af_hi_q;
        default: bus_rdata = '0;
      endcase
    end
  end

  assert_wo_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we && (bus_word == W_BSR || bus_word == W_CLR)) |-> (bus_rdata == 32'h0));
endmodule

// File: tb/sim_gpio_port_regs.sv
module sim_gpio_port_regs;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_we = 1'b0;
  logic [5:0] bus_word = '0;
  logic [3:0] bus_be = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [15:0] lock_mask = '0, pin_in = '0;
  logic [255:0] af_out, af_oe;
  logic [15:0] pin_out, pin_oe, pin_od, pin_pu, pin_pd;
  logic [31:0] pin_mode, pin_speed;
  int nchk = 0, nerr = 0;
  bit done = 0;

  always #5 clk = ~clk;

  gpio_port_regs u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we), .bus_word(bus_word),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .lock_mask(lock_mask),
    .pin_in(pin_in), .af_out(af_out), .af_oe(af_oe), .pin_out(pin_out), .pin_oe(pin_oe),
    .pin_od(pin_od), .pin_pu(pin_pu), .pin_pd(pin_pd), .pin_mode(pin_mode), .pin_speed(pin_speed)
  );

  function automatic bit afo(int p, int f); return ((p * 7 + f * 3) % 5) < 2; endfunction
  function automatic bit afe(int p, int f); return ((p + 2 * f) % 3) != 0; endfunction

  function automatic logic [31:0] lane_merge(logic [31:0] old, logic [31:0] d, logic [3:0] be);
    logic [31:0] r = old;
    for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = d[8*b +: 8];
    return r;
  endfunction

  // field-wise update honouring the lock mask: fw-bit fields, first pin index fp
  function automatic logic [31:0] lock_merge(logic [31:0] old, logic [31:0] d, logic [15:0] lk, int fw, int fp);
    logic [31:0] r = old;
    for (int k = 0; k < 32 / fw; k++)
      if (fp + k < 16 && !lk[fp + k])
        for (int j = 0; j < fw; j++) r[k*fw + j] = d[k*fw + j];
    return r;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] w, logic [31:0] d, logic [3:0] be);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_word = w; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_sel = 0; bus_we = 0; bus_be = 0;
  endtask

  task automatic rd(logic [5:0] w, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_word = w;
    #1 d = bus_rdata;
    bus_sel = 0;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      nerr++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [5:0] regs [7] = '{6'h00, 6'h01, 6'h02, 6'h03, 6'h05, 6'h08, 6'h09};
    logic [31:0] mdl [7] = '{32'hFFFF_FFFF, 0, 0, 0, 0, 0, 0};
    for (int p = 0; p < 16; p++)
      for (int f = 0; f < 16; f++) begin
        af_out[16*p + f] = afo(p, f);
        af_oe[16*p + f]  = afe(p, f);
      end
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    for (int i = 0; i < 7; i++) begin
      rd(regs[i], r);
      chk("R1 reset value", r, mdl[i]);
    end
    chk("R1 no output enable", {16'h0, pin_oe}, 0);

    // R2 / R5 byte-lane sweep
    for (int i = 0; i < 7; i++)
      for (int be = 1; be < 16; be++) begin
        logic [31:0] d;
        d = 32'hA5C3_0F96 ^ (be * 32'h1111_1111) ^ (i * 32'h0101_0303);
        wr(regs[i], d, be[3:0]);
        mdl[i] = lane_merge(mdl[i], d, be[3:0]);
        if (regs[i] == 6'h01 || regs[i] == 6'h05) mdl[i] &= 32'h0000_FFFF;
        rd(regs[i], r);
        chk("R2 lane write / R5 reserved", r, mdl[i]);
      end

    // R3 exhaustive set/clear per pin
    for (int p = 0; p < 16; p++)
      for (int v = 0; v < 8; v++) begin
        logic [15:0] base, exp;
        base = (16'h5A5A & ~(16'h1 << p)) | (16'(v >> 2 & 1) << p);
        wr(6'h05, {16'h0, base}, 4'hF);
        wr(6'h06, {16'(v >> 1 & 1) << p, 16'(v & 1) << p}, 4'hF);
        exp = (v & 1) ? (base | (16'h1 << p)) : ((v & 2) ? (base & ~(16'h1 << p)) : base);
        rd(6'h05, r);
        chk("R3 set/clear", r, {16'h0, exp});
      end
    wr(6'h05, 32'h0, 4'hF);
    wr(6'h06, 32'hFFFF_FFFF, 4'b0011);
    rd(6'h05, r); chk("R3 lanes low only set", r, 32'h0000_FFFF);
    wr(6'h06, 32'hFFFF_FFFF, 4'b1100);
    rd(6'h05, r); chk("R3 lanes high only clear", r, 32'h0);
    wr(6'h06, 32'h0, 4'hF);
    rd(6'h05, r); chk("R3 zero write no effect", r, 32'h0);

    // R4 clear-only register
    wr(6'h05, 32'hFFFF, 4'hF);
    wr(6'h0A, 32'h0000_00F0, 4'hF);
    rd(6'h05, r); chk("R4 clear bits", r, 32'h0000_FF0F);
    wr(6'h0A, 32'hFFFF_0000, 4'hF);
    rd(6'h05, r); chk("R4 upper bits ignored", r, 32'h0000_FF0F);

    // R5 write-only registers read zero
    rd(6'h06, r); chk("R5 set/clear reads 0", r, 0);
    rd(6'h0A, r); chk("R5 clear-only reads 0", r, 0);

    // R6 input sampling
    wr(6'h00, 32'h0, 4'hF);
    for (int k = 0; k < 8; k++) begin
      logic [15:0] pat;
      pat = 16'(k * 16'h3A5B) ^ 16'h00C3;
      @(negedge clk); pin_in = pat;
      rd(6'h04, r);
      chk("R6 input sample", r, {16'h0, pat});
    end
    @(negedge clk);
    pin_in = 16'h1234; bus_sel = 1; bus_we = 0; bus_word = 6'h04;
    #1 r = bus_rdata;
    chk("R6 one-edge latency (old)", r, {16'h0, 16'(7 * 16'h3A5B) ^ 16'h00C3});
    @(negedge clk); #1 r = bus_rdata;
    chk("R6 one-edge latency (new)", r, 32'h1234);
    bus_sel = 0;
    wr(6'h00, 32'h0000_00C0, 4'hF);
    pin_in = 16'hFFFF;
    @(negedge clk);
    rd(6'h04, r); chk("R6 analog pin reads 0", r, 32'h0000_FFF7);

    // R7 lock
    begin
      logic [31:0] nv [6] = '{32'hAAAA_AAAA, 32'hFFFF, 32'hFFFF_FFFF, 32'h5555_5555, 32'hFFFF_FFFF, 32'hEEEE_EEEE};
      logic [5:0] lw [6] = '{6'h00, 6'h01, 6'h02, 6'h03, 6'h08, 6'h09};
      int fws [6] = '{2, 1, 2, 2, 4, 4};
      int fps [6] = '{0, 0, 0, 0, 0, 8};
      for (int i = 0; i < 6; i++) wr(lw[i], 32'h0, 4'hF);
      lock_mask = 16'h8181;
      for (int i = 0; i < 6; i++) begin
        wr(lw[i], nv[i], 4'hF);
        rd(lw[i], r);
        chk("R7 lock freeze", r, lock_merge(32'h0, nv[i], 16'h8181, fws[i], fps[i]) & (i == 1 ? 32'hFFFF : 32'hFFFF_FFFF));
      end
      lock_mask = 16'h0;
    end

    // R8 R9 R11 R12 mux sweep
    for (int m = 0; m < 4; m++)
      for (int si = 0; si < 4; si++)
        for (int od = 0; od < 2; od++)
          for (int q = 0; q < 2; q++) begin
            logic [31:0] lo, hi;
            logic [15:0] odr, eoe, eout;
            int s;
            s = si * 5;
            odr = q ? 16'h5A5A : 16'hA5A5;
            for (int p = 0; p < 8; p++) begin
              lo[4*p +: 4] = 4'((s + p) % 16);
              hi[4*p +: 4] = 4'((s + p + 8) % 16);
            end
            wr(6'h00, {16{m[1:0]}}, 4'hF);
            wr(6'h08, lo, 4'hF);
            wr(6'h09, hi, 4'hF);
            wr(6'h01, od ? 32'hFFFF : 32'h0, 4'hF);
            wr(6'h05, {16'h0, odr}, 4'hF);
            @(negedge clk);
            for (int p = 0; p < 16; p++) begin
              int f;
              bit v, rq;
              f = (s + p) % 16;
              v = (m == 2) ? afo(p, f) : odr[p];
              rq = (m == 1) || (m == 2 && afe(p, f));
              eout[p] = v;
              eoe[p] = rq && !(od == 1 && v);
            end
            #1;
            chk(od ? "R9 open-drain enable" : "R8 R11 output enable", {16'h0, pin_oe}, {16'h0, eoe});
            chk("R8 R11 driven value", {16'h0, pin_out}, {16'h0, eout});
            chk("R9 open-drain flag", {16'h0, pin_od}, od ? 32'hFFFF : 32'h0);
            chk("R12 mode output", pin_mode, {16{m[1:0]}});
          end

    // R10 pull decode
    for (int v = 0; v < 4; v++) begin
      logic [31:0] pw;
      logic [15:0] eu, ed;
      for (int p = 0; p < 16; p++) begin
        pw[2*p +: 2] = 2'((p + v) % 4);
        eu[p] = ((p + v) % 4) == 1;
        ed[p] = ((p + v) % 4) == 2;
      end
      wr(6'h03, pw, 4'hF);
      @(negedge clk); #1;
      chk("R10 pull-up", {16'h0, pin_pu}, {16'h0, eu});
      chk("R10 pull-down", {16'h0, pin_pd}, {16'h0, ed});
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule